// File: doc/BRIEF.md
# Three-Stage Elastic Transform Pipeline

This block carries data words from an input handshake to an output handshake through three fixed transform stages. Every stage sits between two small queues. Each queue holds up to two words, so four queues are in the path: one at the input, two between stages, one at the output. A stage acts only when the queue before it has a word and the queue after it has room. In that cycle it takes the head word, applies its transform and writes the result into the next queue. The three transforms are fixed: add a constant, then XOR with a mask, then rotate left by a fixed amount.

Each queue is built from two word registers with a valid flag each. The head word always sits in the first register. The queues are arranged so that a word can enter and another can leave in the same clock without any word being lost or duplicated. Every stage can therefore act on every clock. With words always offered and the output always ready, the block delivers one result per cycle. When the output stalls, the queues absorb up to eight words before the input is refused.

Top module: `elastic_pipe3`

## Requirements
- R1: After a synchronous active-low reset, every queue is empty: `out_valid` is 0 and `in_ready` is 1.
- R2: Each accepted word `x` leaves as `rotl(((x + ADD_K) mod 2^W) ^ XOR_M, ROT_N)`. Words leave in the order they were accepted, none is lost and none is repeated. The defaults are W=16, ADD_K=0x0013, XOR_M=0xA5C3 and ROT_N=3.
- R3: A word is accepted on a rising edge exactly when `in_valid` and `in_ready` are both 1. A word offered while `in_ready` is 0 has no effect: it never appears at the output.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R5: With `in_valid` held at 1 and `out_ready` held at 1, the block accepts a word every cycle. Once the first result appears, `out_valid` is 1 on every cycle.
- R6: A queue holding one word that receives and releases a word on the same edge still holds exactly one word, the new one, at its head. A queue never holds a word in its second register while its head register is empty.
- R7: With `out_ready` held at 0, an empty block accepts exactly 8 words. `in_ready` is 0 from then on.
- R8: On an empty block, a word accepted on edge k makes `out_valid` 1 after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input queue has room |
| in_data | input | W | Input word |
| out_valid | output | 1 | Output queue head holds a result |
| out_ready | input | 1 | Consumer takes the head this cycle |
| out_data | output | W | Head result |

## Verification
The bench targets three cases. The first is a queue that holds one word and receives and releases a word on the same edge. A design that got this wrong would leave the new word behind an empty head and stall or drop it, which breaks the one-result-per-clock stream and the output order. The second is full backpressure. A wrong capacity count or a lost guard would show as a different number of accepted words, or as a refused word leaking out later. The third is random stalls on both handshakes, checked every clock against a queue model. This catches a changed head during a stall, a duplicated word or a transform applied in the wrong order.

// File: rtl/elastic_pipe3.sv
module elastic_pipe3 #(
  parameter int W     = 16,
  parameter logic [W-1:0] ADD_K = 16'h0013,
  parameter logic [W-1:0] XOR_M = 16'hA5C3,
  parameter int ROT_N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int NQ = 4;
  localparam int NS = NQ - 1;

  logic [W-1:0] slot_a [NQ];
  logic [W-1:0] slot_b [NQ];
  logic [W-1:0] q_din  [NQ];
  logic [NQ-1:0] a_ok, b_ok, q_enq, q_deq;
  logic [NS-1:0] fire;

  function automatic logic [W-1:0] xform(input int s, input logic [W-1:0] x);
    logic [W-1:0] r;
    case (s)
      0:       r = x + ADD_K;
      1:       r = x ^ XOR_M;
      default: r = (x << ROT_N) | (x >> (W - ROT_N));
    endcase
    return r;
  endfunction

  assign in_ready  = !b_ok[0];
  assign q_enq[0]  = in_valid && in_ready;
  assign q_din[0]  = in_data;
  assign out_valid = a_ok[NQ-1];
  assign out_data  = slot_a[NQ-1];
  assign q_deq[NQ-1] = out_valid && out_ready;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    assign fire[s]     = a_ok[s] && !b_ok[s+1];
    assign q_deq[s]    = fire[s];
    assign q_enq[s+1]  = fire[s];
    assign q_din[s+1]  = xform(s, slot_a[s]);
  end

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_ok[q] <= 1'b0;
        b_ok[q] <= 1'b0;
      end else if (q_enq[q] && q_deq[q]) begin
        slot_a[q] <= q_din[q];
      end else if (q_enq[q]) begin
        if (a_ok[q]) begin
          slot_b[q] <= q_din[q];
          b_ok[q]   <= 1'b1;
        end else begin
          slot_a[q] <= q_din[q];
          a_ok[q]   <= 1'b1;
        end
      end else if (q_deq[q]) begin
        if (b_ok[q]) begin
          slot_a[q] <= slot_b[q];
          b_ok[q]   <= 1'b0;
        end else begin
          a_ok[q]   <= 1'b0;
        end
      end
    end
  end
endmodule

module elastic_pipe3_chk #(
  parameter int W  = 16,
  parameter int NQ = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data,
  input logic [NQ-1:0] a_ok,
  input logic [NQ-1:0] b_ok,
  input logic [NQ-1:0] q_enq,
  input logic [NQ-1:0] q_deq
);
  AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> !out_valid && in_ready); // R1
  AST_READY_FALL_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R4
  for (genvar q = 0; q < NQ; q++) begin : g_q
    AST_NO_HOLLOW_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_ok[q] && !a_ok[q])); // R6
    AST_PASS_THROUGH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      a_ok[q] && !b_ok[q] && q_enq[q] && q_deq[q] |=> a_ok[q] && !b_ok[q]); // R6
  end
endmodule

bind elastic_pipe3 elastic_pipe3_chk #(.W(W), .NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .a_ok(a_ok), .b_ok(b_ok), .q_enq(q_enq), .q_deq(q_deq)
);

// File: tb/tb_elastic_pipe3.sv
`timescale 1ns/1ps
module tb_elastic_pipe3;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;
  int checks = 0, errors = 0;
  int accepted = 0, delivered = 0;
  logic [W-1:0] m0[$], m1[$], m2[$], m3[$];
  logic [W-1:0] next_word = 16'h1000;

  always #2 clk = ~clk;

  elastic_pipe3 dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  function automatic logic [W-1:0] t_add(logic [W-1:0] x); return x + 16'h0013; endfunction
  function automatic logic [W-1:0] t_xor(logic [W-1:0] x); return x ^ 16'hA5C3; endfunction
  function automatic logic [W-1:0] t_rot(logic [W-1:0] x); return {x[W-4:0], x[W-1:W-3]}; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m0.delete(); m1.delete(); m2.delete(); m3.delete();
    end else begin
      automatic bit f0 = m0.size() > 0 && m1.size() < 2;
      automatic bit f1 = m1.size() > 0 && m2.size() < 2;
      automatic bit f2 = m2.size() > 0 && m3.size() < 2;
      automatic bit a  = in_valid && m0.size() < 2;
      automatic bit d  = out_ready && m3.size() > 0;
      automatic logic [W-1:0] h0 = f0 ? m0[0] : '0;
      automatic logic [W-1:0] h1 = f1 ? m1[0] : '0;
      automatic logic [W-1:0] h2 = f2 ? m2[0] : '0;
      if (d)  void'(m3.pop_front());
      if (f2) begin void'(m2.pop_front()); m3.push_back(t_rot(h2)); end
      if (f1) begin void'(m1.pop_front()); m2.push_back(t_xor(h1)); end
      if (f0) begin void'(m0.pop_front()); m1.push_back(t_add(h0)); end
      if (a)  m0.push_back(in_data);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(in_ready == (m0.size() < 2), "R3 in_ready vs model", in_ready, m0.size() < 2);
    chk(out_valid == (m3.size() > 0), "R6 out_valid vs model", out_valid, m3.size() > 0);
    if (out_valid && m3.size() > 0)
      chk(out_data == m3[0], "R2 out_data vs model", out_data, m3[0]);
  endtask

  task automatic tick();
    if (in_valid && in_ready) accepted++;
    if (out_valid && out_ready) delivered++;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic offer(input bit v);
    in_valid = v;
    if (v) begin in_data = next_word; next_word = next_word * 16'd31 + 16'd7; end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, run;
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready, "R1 in_ready after reset", in_ready, 1);

    // R8 latency
    out_ready = 1'b1;
    offer(1); tick(); offer(0);
    lat = 0;
    while (!out_valid && lat < 10) begin tick(); lat++; end
    chk(lat == 3, "R8 latency edges", lat, 3);
    chk(out_data == t_rot(t_xor(t_add(16'h1000))), "R2 first word transform", out_data,
        t_rot(t_xor(t_add(16'h1000))));
    repeat (5) tick();

    // R5 throughput
    accepted = 0; delivered = 0; run = 0;
    for (int i = 0; i < 40; i++) begin
      offer(1); tick();
      if (i >= 10 && out_valid) run++;
    end
    chk(accepted == 40, "R5 accepted every cycle", accepted, 40);
    chk(run == 30, "R5 one result per clock", run, 30);
    offer(0);
    repeat (10) tick();
    chk(delivered == accepted, "R2 all streamed words delivered", delivered, accepted);

    // R7 fill with stalled output, R3 refused words
    out_ready = 1'b0; accepted = 0;
    for (int i = 0; i < 12; i++) begin offer(1); tick(); end
    chk(accepted == 8, "R7 capacity", accepted, 8);
    chk(!in_ready, "R7 in_ready low when full", in_ready, 0);
    held = out_data;
    for (int i = 0; i < 4; i++) begin offer(1); tick(); end
    chk(out_valid && out_data == held, "R4 head stable while stalled", out_data, held);
    chk(accepted == 8, "R3 refused words not accepted", accepted, 8);
    offer(0); out_ready = 1'b1; delivered = 0;
    repeat (15) tick();
    chk(delivered == 8, "R3 only accepted words delivered", delivered, 8);
    chk(!out_valid, "R2 drained empty", out_valid, 0);

    // random stalls on both sides
    accepted = 0; delivered = 0;
    for (int i = 0; i < 400; i++) begin
      offer($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 2) != 0);
      tick();
    end
    offer(0); out_ready = 1'b1;
    repeat (15) tick();
    chk(delivered == accepted, "R2 random run counts", delivered, accepted);

    // R1 reset again mid-traffic
    offer(1); out_ready = 1'b0;
    repeat (5) tick();
    rst_n = 1'b0; tick(); rst_n = 1'b1; offer(0);
    chk(!out_valid && in_ready, "R1 reset clears queues", out_valid, 0);
    repeat (4) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule